// File: doc/BRIEF.md
# Parallel Flash Query and Identifier Read Formatter

This block builds the read data that a bank of identical parallel flash devices, placed side by side on one data bus, returns while the bank is in query mode or in identifier mode. A read presents a byte offset, an access size and a mode bit. The block rescales the offset into a per-device index, which depends on the bank width, the device width and the largest width the part supports. It then looks up either a small query parameter table or the two identifier values. If the data comes from a wide part run in byte mode, it widens the entry. Finally it copies the per-device answer into every device lane of the bank.

The three width settings are two-bit log2 codes: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. They are sampled only while reset is held. The result appears one clock after the read strobe, together with a one-cycle valid flag. An access wider than the bank is put together from consecutive bank-wide answers.

Top module: `pflash_query_fmt`

## Requirements
- R1: While `rst_n` is low at a rising edge, `rd_valid` and `rd_data` are 0 after that edge.
- R2: `rd_valid` is high for exactly the cycle after each cycle with `rd_req` high. `rd_data` carries the answer in that same cycle.
- R3: The per-device index is the slice offset shifted right by `bank_lg + max_lg - dev_lg`.
- R4: In query mode (`rd_ident`=0), an index of `TBL_DEPTH` (default 82) or more gives a zero answer. No wrap-around is applied.
- R5: If `dev_lg` differs from `max_lg` in query mode, the table byte fills every byte of the device answer when `dev_lg`=0. For any other `dev_lg` the answer is zero.
- R6: When the device is narrower than the bank, byte j of a bank answer equals byte (j mod device bytes) of the device answer. A device answer is the table byte in byte 0 followed by zero bytes, or the zero-extended 16-bit identifier.
- R7: In identifier mode (`rd_ident`=1), only the low 8 bits of the index are decoded. Index 0 gives `MFR_ID`, index 1 gives `DEV_ID`, and every other value gives zero.
- R8: For an access wider than the bank, slice s fills bytes s*B..s*B+B-1 (B = bank bytes). Slice s uses the offset `rd_ofs + s*B`, modulo 2^OFS_W.
- R9: The table holds fixed non-zero entries, and every other entry is zero:
  - 0x10..0x12 = 0x51 0x52 0x59
  - 0x13 = 0x01
  - 0x15 = 0x31
  - 0x31..0x35 = 0x50 0x52 0x49 0x31 0x30
- R10: Changes to `cfg_*` inputs while `rst_n` is high have no effect on `cfg_err` or on read data.
- R11: `cfg_err` is 1 and every answer is zero when the sampled configuration has any code above 2, `dev_lg > bank_lg`, or `max_lg < dev_lg`.
- R12: `rd_size` is a log2 byte count. Bytes at and above 2^`rd_size` are zero, and `rd_size`=3 gives a zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| rd_req | input | 1 | Read strobe |
| rd_ident | input | 1 | 0 = query table, 1 = identifier values |
| rd_ofs | input | OFS_W | Byte offset of the read |
| rd_size | input | 2 | log2 of access bytes |
| cfg_bank_lg | input | 2 | log2 of bank width in bytes |
| cfg_dev_lg | input | 2 | log2 of device width in bytes |
| cfg_max_lg | input | 2 | log2 of the device's largest supported width |
| rd_valid | output | 1 | Answer valid, one cycle after `rd_req` |
| rd_data | output | 32 | Formatted answer |
| cfg_err | output | 1 | Sampled configuration is invalid |

## Verification
A wrong shift amount or a wrong lane mask shows up on the very next `rd_valid` as a table letter in the wrong byte, or as a letter missing from some lanes. The replicated "QRY" and "PRI" entries make such errors visible within a single read. A stale or re-sampled configuration register changes the answer to the first read after a `cfg_*` change, so that read exposes it at once. Erroneous index wrap-around only shows for offsets whose low bits alias a populated entry, so those offsets are driven directly.

// File: rtl/qfmt_pkg.sv
package qfmt_pkg;

   localparam int BUS_BYTES = 4;
   localparam int BUS_W     = 8 * BUS_BYTES;

   typedef struct packed {
      logic [1:0] bank_lg;
      logic [1:0] dev_lg;
      logic [1:0] max_lg;
   } qcfg_t;

   // Fixed query entries; every other location reads as zero.
   function automatic logic [7:0] tbl_byte(input logic [7:0] idx);
      case (idx)
         8'h10:   tbl_byte = 8'h51;
         8'h11:   tbl_byte = 8'h52;
         8'h12:   tbl_byte = 8'h59;
         8'h13:   tbl_byte = 8'h01;
         8'h15:   tbl_byte = 8'h31;
         8'h31:   tbl_byte = 8'h50;
         8'h32:   tbl_byte = 8'h52;
         8'h33:   tbl_byte = 8'h49;
         8'h34:   tbl_byte = 8'h31;
         8'h35:   tbl_byte = 8'h30;
         default: tbl_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/qfmt_slice.sv
module qfmt_slice
   import qfmt_pkg::*;
#(
   parameter int          OFS_W     = 16,
   parameter int          TBL_DEPTH = 82,
   parameter logic [15:0] MFR_ID    = 16'h0000,
   parameter logic [15:0] DEV_ID    = 16'h0000
) (
   input  qcfg_t              cfg,
   input  logic               ident,
   input  logic [OFS_W-1:0]   ofs,
   output logic [BUS_W-1:0]   resp
);

   localparam logic [OFS_W:0] DEPTH_V = (OFS_W+1)'(TBL_DEPTH);

   logic [2:0]       shamt;
   logic [OFS_W-1:0] idx;
   logic             past_end;
   logic [7:0]       tbyte;
   logic [BUS_W-1:0] dword;
   logic [1:0]       dmask;
   logic [2:0]       bank_bytes;
   logic [1:0]       sel;

   always_comb begin
      shamt      = 3'(cfg.bank_lg) + 3'(cfg.max_lg) - 3'(cfg.dev_lg);
      idx        = ofs >> shamt;
      past_end   = ({1'b0, idx} >= DEPTH_V);
      tbyte      = past_end ? 8'h00 : tbl_byte(idx[7:0]);
      dmask      = 2'((3'd1 << cfg.dev_lg) - 3'd1);
      bank_bytes = 3'd1 << cfg.bank_lg;

      if (ident) begin
         case (idx[7:0])
            8'd0:    dword = {16'h0000, MFR_ID};
            8'd1:    dword = {16'h0000, DEV_ID};
            default: dword = '0;
         endcase
      end else if (cfg.dev_lg != cfg.max_lg) begin
         dword = (cfg.dev_lg == 2'd0) ? {BUS_BYTES{tbyte}} : '0;
      end else begin
         dword = {24'h000000, tbyte};
      end

      resp = '0;
      sel  = '0;
      for (int k = 0; k < BUS_BYTES; k++) begin
         if (3'(k) < bank_bytes) begin
            sel = 2'(k) & dmask;
            resp[8*k +: 8] = dword[{sel, 3'b000} +: 8];
         end
      end
   end

   always_comb begin
      // R7
      if (ident && idx[7:0] > 8'd1) begin
         id_other_zero_chk: assert (resp == '0);
      end
      // R4
      if (!ident && past_end) begin
         past_table_zero_chk: assert (resp == '0);
      end
   end

endmodule

// File: rtl/qfmt_pack.sv
module qfmt_pack
   import qfmt_pkg::*;
(
   input  logic [BUS_BYTES-1:0][BUS_W-1:0] slice_rsp,
   input  logic [1:0]                      bank_lg,
   input  logic [1:0]                      size,
   output logic [BUS_W-1:0]                data
);

   logic [1:0] s;
   logic [1:0] b;
   logic [1:0] bmask;
   logic [2:0] nbytes;

   always_comb begin
      data   = '0;
      s      = '0;
      b      = '0;
      bmask  = 2'((3'd1 << bank_lg) - 3'd1);
      nbytes = 3'd1 << size;
      for (int k = 0; k < BUS_BYTES; k++) begin
         if (size != 2'd3 && 3'(k) < nbytes) begin
            s = 2'(k >> bank_lg);
            b = 2'(k) & bmask;
            data[8*k +: 8] = slice_rsp[s][{b, 3'b000} +: 8];
         end
      end
   end

endmodule

// File: rtl/pflash_query_fmt.sv
module pflash_query_fmt
   import qfmt_pkg::*;
#(
   parameter int          OFS_W     = 16,
   parameter int          TBL_DEPTH = 82,
   parameter logic [15:0] MFR_ID    = 16'h00A7,
   parameter logic [15:0] DEV_ID    = 16'h5C3E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             rd_ident,
   input  logic [OFS_W-1:0] rd_ofs,
   input  logic [1:0]       rd_size,
   input  logic [1:0]       cfg_bank_lg,
   input  logic [1:0]       cfg_dev_lg,
   input  logic [1:0]       cfg_max_lg,
   output logic             rd_valid,
   output logic [31:0]      rd_data,
   output logic             cfg_err
);

   generate
      if (OFS_W < 9 || OFS_W > 32) begin : g_bad_ofs
         $error("OFS_W must lie in 9..32");
      end
      if (TBL_DEPTH < 54 || TBL_DEPTH > 256) begin : g_bad_depth
         $error("TBL_DEPTH must lie in 54..256");
      end
   endgenerate

   qcfg_t cfg_q;
   logic  err_q;
   logic  err_d;

   always_comb begin
      err_d = (cfg_bank_lg == 2'd3) || (cfg_dev_lg == 2'd3) || (cfg_max_lg == 2'd3)
           || (cfg_dev_lg > cfg_bank_lg) || (cfg_max_lg < cfg_dev_lg);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '{bank_lg: cfg_bank_lg, dev_lg: cfg_dev_lg, max_lg: cfg_max_lg};
         err_q <= err_d;
      end
   end

   logic [BUS_BYTES-1:0][BUS_W-1:0] slice_rsp;
   logic [BUS_W-1:0]                packed_data;

   for (genvar s = 0; s < BUS_BYTES; s++) begin : g_slice
      logic [OFS_W-1:0] s_ofs;
      assign s_ofs = rd_ofs + (OFS_W'(s) << cfg_q.bank_lg);
      qfmt_slice #(
         .OFS_W     (OFS_W),
         .TBL_DEPTH (TBL_DEPTH),
         .MFR_ID    (MFR_ID),
         .DEV_ID    (DEV_ID)
      ) i_slice (
         .cfg   (cfg_q),
         .ident (rd_ident),
         .ofs   (s_ofs),
         .resp  (slice_rsp[s])
      );
   end

   qfmt_pack i_pack (
      .slice_rsp (slice_rsp),
      .bank_lg   (cfg_q.bank_lg),
      .size      (rd_size),
      .data      (packed_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_data <= err_q ? '0 : packed_data;
         end
      end
   end

   assign cfg_err = err_q;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!rd_valid && rd_data == '0));

   // R2
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   // R2
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(cfg_err));

   // R11
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && cfg_err) |-> rd_data == '0);

   // R12
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_size == 2'd0) |=> rd_data[31:8] == '0);

endmodule

// File: tb/test_pflash_query_fmt.sv
module test_pflash_query_fmt;

   localparam int          OFS_W = 16;
   localparam int          DEPTH = 82;
   localparam logic [15:0] MFR   = 16'h00A7;
   localparam logic [15:0] DEVI  = 16'h5C3E;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rd_req = 1'b0;
   logic             rd_ident = 1'b0;
   logic [OFS_W-1:0] rd_ofs = '0;
   logic [1:0]       rd_size = '0;
   logic [1:0]       cfg_bank_lg = '0;
   logic [1:0]       cfg_dev_lg = '0;
   logic [1:0]       cfg_max_lg = '0;
   logic             rd_valid;
   logic [31:0]      rd_data;
   logic             cfg_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int cur_bl, cur_dl, cur_ml;

   always #2.5 clk = ~clk;

   pflash_query_fmt #(
      .OFS_W(OFS_W), .TBL_DEPTH(DEPTH), .MFR_ID(MFR), .DEV_ID(DEVI)
   ) i_pflash_query_fmt (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ident(rd_ident),
      .rd_ofs(rd_ofs), .rd_size(rd_size), .cfg_bank_lg(cfg_bank_lg),
      .cfg_dev_lg(cfg_dev_lg), .cfg_max_lg(cfg_max_lg),
      .rd_valid(rd_valid), .rd_data(rd_data), .cfg_err(cfg_err)
   );

   function automatic int ref_tbl(int i);
      int v;
      v = 0;
      if (i >= 16 && i <= 18) v = (i == 16) ? 'h51 : (i == 17) ? 'h52 : 'h59;
      else if (i == 'h13) v = 1;
      else if (i == 'h15) v = 'h31;
      else if (i == 'h31) v = 'h50;
      else if (i == 'h32) v = 'h52;
      else if (i == 'h33) v = 'h49;
      else if (i == 'h34) v = 'h31;
      else if (i == 'h35) v = 'h30;
      return v;
   endfunction

   function automatic logic [31:0] ref_read(int bl, int dl, int ml, bit id, int ofs, int sz);
      logic [31:0] r;
      int bb, db, mb, s, j, dbyte, off, idx, v, idv;
      r = '0;
      if (bl > 2 || dl > 2 || ml > 2 || dl > bl || ml < dl || sz > 2) return r;
      bb = 1 << bl; db = 1 << dl; mb = 1 << ml;
      for (int k = 0; k < (1 << sz); k++) begin
         s     = k / bb;
         j     = k % bb;
         dbyte = j % db;
         off   = (ofs + s * bb) % 65536;
         idx   = off >> (bl + ml - dl);
         v     = 0;
         if (id) begin
            idv = ((idx % 256) == 0) ? int'(MFR) : ((idx % 256) == 1) ? int'(DEVI) : 0;
            v   = (idv >> (8 * dbyte)) & 255;
         end else if (idx < DEPTH) begin
            if (db != mb) v = (db == 1) ? ref_tbl(idx) : 0;
            else          v = (dbyte == 0) ? ref_tbl(idx) : 0;
         end
         r[8*k +: 8] = 8'(v);
      end
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_reset(int bl, int dl, int ml);
      @(negedge clk);
      rst_n = 1'b0; rd_req = 1'b0;
      cfg_bank_lg = 2'(bl); cfg_dev_lg = 2'(dl); cfg_max_lg = 2'(ml);
      repeat (3) @(negedge clk);
      check("R1 valid in reset", {31'd0, rd_valid}, 32'd0);
      check("R1 data in reset", rd_data, 32'd0);
      rst_n = 1'b1;
      cur_bl = bl; cur_dl = dl; cur_ml = ml;
   endtask

   task automatic do_read(bit id, int ofs, int sz, output logic [31:0] got);
      rd_ident = id; rd_ofs = OFS_W'(ofs); rd_size = 2'(sz); rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      if (rd_valid !== 1'b1) begin
         n_fail++;
         $display("FAIL R2 valid: got %b expected 1", rd_valid);
      end
      got = rd_data;
   endtask

   task automatic rd_lit(string tag, bit id, int ofs, int sz, logic [31:0] exp);
      logic [31:0] g;
      do_read(id, ofs, sz, g);
      check(tag, g, exp);
   endtask

   task automatic rd_ref(string tag, bit id, int ofs, int sz);
      logic [31:0] g;
      do_read(id, ofs, sz, g);
      check(tag, g, ref_read(cur_bl, cur_dl, cur_ml, id, ofs, sz));
   endtask

   int cfgs [10][3] = '{'{0,0,0}, '{1,1,1}, '{2,2,2}, '{2,1,1}, '{2,0,0},
                        '{1,0,1}, '{2,0,1}, '{2,0,2}, '{2,1,2}, '{1,0,0}};

   initial begin
      void'($urandom(32'd20240611));

      do_reset(0, 0, 0);
      check("R11 cfg_err clear", {31'd0, cfg_err}, 32'd0);
      rd_lit("R9 R3 Q entry", 1'b0, 'h10, 0, 32'h00000051);
      @(negedge clk);
      check("R2 valid drops", {31'd0, rd_valid}, 32'd0);
      rd_lit("R8 four slices", 1'b0, 'h12, 2, 32'h31000159);
      rd_lit("R4 index 0x52", 1'b0, 'h52, 0, 32'h0);
      rd_lit("R4 no wrap 0x131", 1'b0, 'h131, 0, 32'h0);
      rd_lit("R7 device id low byte", 1'b1, 1, 0, 32'h0000003E);
      rd_lit("R12 size code 3", 1'b0, 'h10, 3, 32'h0);

      do_reset(1, 1, 1);
      rd_lit("R3 R6 x16 Q", 1'b0, 'h20, 1, 32'h00000051);
      rd_lit("R7 manufacturer", 1'b1, 0, 1, 32'h000000A7);
      rd_lit("R7 device", 1'b1, 2, 1, 32'h00005C3E);
      rd_lit("R7 lock location zero", 1'b1, 4, 1, 32'h0);
      rd_lit("R7 low 8 bits only", 1'b1, 'h200, 1, 32'h000000A7);

      do_reset(2, 1, 1);
      rd_lit("R6 two lanes", 1'b0, 'h40, 2, 32'h00510051);

      do_reset(2, 0, 1);
      rd_lit("R5 byte mode fill", 1'b0, 'h80, 2, 32'h51515151);

      do_reset(2, 1, 2);
      rd_lit("R5 unsupported combo", 1'b0, 'h80, 2, 32'h0);

      do_reset(2, 2, 2);
      rd_lit("R9 P entry", 1'b0, 'hC4, 2, 32'h00000050);
      rd_lit("R12 narrow read", 1'b0, 'h40, 0, 32'h00000051);
      // R10: inputs change after reset, sampled configuration must persist
      cfg_bank_lg = 2'd0; cfg_dev_lg = 2'd1; cfg_max_lg = 2'd0;
      @(negedge clk);
      check("R10 cfg_err unchanged", {31'd0, cfg_err}, 32'd0);
      rd_lit("R10 old config in use", 1'b0, 'h44, 2, 32'h00000052);

      do_reset(0, 1, 1);
      check("R11 dev wider than bank", {31'd0, cfg_err}, 32'd1);
      rd_lit("R11 data zero", 1'b1, 0, 0, 32'h0);
      do_reset(1, 1, 0);
      check("R11 max below dev", {31'd0, cfg_err}, 32'd1);
      do_reset(3, 0, 0);
      check("R11 code 3", {31'd0, cfg_err}, 32'd1);
      rd_lit("R11 data zero code 3", 1'b0, 'h10, 0, 32'h0);

      foreach (cfgs[c]) begin
         do_reset(cfgs[c][0], cfgs[c][1], cfgs[c][2]);
         for (int n = 0; n < 200; n++) begin
            int o, sz;
            bit id;
            o  = int'($urandom % 32'h400);
            if (n % 16 == 0) o = int'($urandom % 32'h10000);
            sz = int'($urandom % 4);
            id = 1'($urandom % 2);
            rd_ref("R3 R5 R6 R8 R12 random", id, o, sz);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog: got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule